// File: doc/BRIEF.md
# Display Memory Access Sequencer

This block drives an external byte-wide static RAM that holds the picture and character-pattern data of a display controller. All accesses run on one master clock. Time is cut into fixed slots of three clocks. In each slot the block issues one read, one write, or nothing. The chip-enable strobe stays high for the first clock of a slot and goes low for the other two. Because the whole window is fixed, a slow and inexpensive RAM can sit on the bus.

Two internal clients share the slots. The screen-refresh fetcher asks for reads: it holds a request and an address until it sees an accept pulse, and it gets the byte back later with a one-clock valid pulse. The host side posts writes into a single-entry buffer. That write is issued in the next slot that the fetcher does not claim. The full 64 KB space is reachable. The top 4 KB normally keeps user character patterns and the rest keeps display data; the sequencer treats every address the same way.

The data lines are split into an outgoing byte, an output-enable and an incoming byte. The outgoing byte works as a bus keeper. It keeps showing the last byte written until a byte read from the RAM replaces it.

Top module: `dispmem_seq`

## Requirements
- R1: Every access occupies exactly three clocks: `mem_ce_n` is high in the first clock of the slot and low in the second and third, then returns high.
- R2: `mem_addr` carries the access address from the first clock of the slot and does not change while `mem_ce_n` is low.
- R3: In a read slot `mem_rd_n` is low from the first clock of the slot and stays low for one more clock after `mem_ce_n` returns high. `mem_rd_n` and `mem_wr_n` are never both low while `mem_ce_n` is low.
- R4: In a write slot `mem_wr_n` is low, `mem_dq_oe` is high and `mem_dq_out` holds the write byte from the first clock of the slot through the third clock. All three are set before `mem_ce_n` falls.
- R5: `mem_dq_out` changes only when a write byte is placed on it or a read byte is captured. While `mem_dq_oe` is low it keeps the last written byte, and after a read it shows the byte just read.
- R6: The byte on `mem_dq_in` is sampled at the end of the third clock of a read slot. It appears on `rd_data` with `rd_valid` high for exactly one clock: the clock right after that slot.
- R7: `fetch_ack` pulses in the last clock of a slot when `fetch_req` is high. The read slot begins on the next clock.
- R8: A pending fetch takes the slot ahead of a buffered write. The buffered write waits, with `host_wr_ready` low, and is issued in the first slot with no fetch pending.
- R9: With no request, a slot keeps `mem_ce_n`, `mem_rd_n` and `mem_wr_n` high. Slots start every three clocks, so a fetch held high is accepted once every three clocks.
- R10: While `rst_n` is low at a clock edge, the following hold after that edge: `mem_ce_n`, `mem_rd_n` and `mem_wr_n` high, `mem_dq_oe` and `rd_valid` low, and the write buffer empty (`host_wr_ready` high). A write that was still buffered is dropped.
- R11: A read returns the byte last written to the same address, including the bottom address 0x0000 and the character-pattern region 0xF000 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_req | input | 1 | Refresh read request, held until accepted |
| fetch_addr | input | 16 | Refresh read address |
| fetch_ack | output | 1 | Read request accepted this clock |
| rd_valid | output | 1 | One-clock pulse: rd_data is valid |
| rd_data | output | 8 | Byte returned by the last read |
| host_wr_req | input | 1 | Host write request, taken when host_wr_ready is high |
| host_wr_addr | input | 16 | Host write address |
| host_wr_data | input | 8 | Host write byte |
| host_wr_ready | output | 1 | Write buffer is empty |
| mem_addr | output | 16 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_rd_n | output | 1 | RAM read strobe, active low |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Outgoing data byte and bus keeper |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Incoming data byte from the RAM |

## Verification
After `fetch_ack` is seen, the read slot starts on the next edge. Its strobes are checked in each of the three clocks that follow. The read byte is due on `rd_valid` four edges after the accept, and the bench checks there that it is one clock wide. A buffered write appears in the first slot boundary with no pending fetch. When a fetch competes, the write slot starts exactly three clocks after the read slot. The bench waits for the falling edge of the write strobe and checks each clock of the slot from there. Every sample is taken on the falling clock edge, after the outputs from the preceding rising edge have settled.

// File: rtl/dispmem_pkg.sv
// Package dispmem_pkg
// Shared constants and types for the display memory sequencer.
// Assumes a slot of three clocks; the first clock has enable high.
package dispmem_pkg;
    localparam int SLOT_LEN = 3;
    localparam int PH_W     = $clog2(SLOT_LEN);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } mem_op_e;
endpackage

// File: rtl/dms_slot_timer.sv
// Module dms_slot_timer
// Free-running phase counter that cuts time into fixed access slots.
// Assumes: reset parks the counter on the last phase, so the first clock
// after reset is a slot boundary.
module dms_slot_timer
    import dispmem_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            slot_end
);
    localparam logic [PH_W-1:0] LAST = PH_W'(SLOT_LEN - 1);

    // Advance the phase and wrap it at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase <= LAST;
        else if (phase == LAST) phase <= '0;
        else                 phase <= phase + 1'b1;
    end

    // Flag the last clock of a slot.
    always_comb slot_end = (phase == LAST);
endmodule

// File: rtl/dms_wr_buffer.sv
// Module dms_wr_buffer
// Single-entry holding buffer for host writes.
// Assumes: push is only requested while empty; pop only while full.
module dms_wr_buffer #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    // Track occupancy; reset drops any held entry.
    always_ff @(posedge clk) begin
        if (!rst_n)            full <= 1'b0;
        else if (push && !full) full <= 1'b1;
        else if (pop)          full <= 1'b0;
    end

    // Capture address and byte when the entry is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            data <= '0;
        end else if (push && !full) begin
            addr <= push_addr;
            data <= push_data;
        end
    end
endmodule

// File: rtl/dms_arbiter.sv
// Module dms_arbiter
// Picks the operation for the next slot at each slot boundary.
// Assumes: refresh reads outrank host writes; the decision is combinational
// and takes effect on the clock edge that ends the slot.
module dms_arbiter
    import dispmem_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          slot_end,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    input  logic          buf_full,
    input  logic [AW-1:0] buf_addr,
    output mem_op_e       next_op,
    output logic [AW-1:0] next_addr,
    output logic          fetch_ack,
    output logic          buf_pop
);
    // Priority choice: fetch first, then the buffered write, else idle.
    always_comb begin
        next_op   = OP_IDLE;
        next_addr = buf_addr;
        fetch_ack = 1'b0;
        buf_pop   = 1'b0;
        if (slot_end) begin
            if (fetch_req) begin
                next_op   = OP_READ;
                next_addr = fetch_addr;
                fetch_ack = 1'b1;
            end else if (buf_full) begin
                next_op = OP_WRITE;
                buf_pop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dms_bus_ctrl.sv
// Module dms_bus_ctrl
// Holds the current slot's operation and address. It shapes the RAM
// strobes, keeps the data byte and captures read data.
// Assumes: new_op/new_addr are valid only when slot_end is high; phase 0
// is the enable-high clock.
module dms_bus_ctrl
    import dispmem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            slot_end,
    input  mem_op_e         new_op,
    input  logic [AW-1:0]   new_addr,
    input  logic [DW-1:0]   wr_byte,
    input  logic [DW-1:0]   mem_dq_in,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_ce_n,
    output logic            mem_rd_n,
    output logic            mem_wr_n,
    output logic [DW-1:0]   mem_dq_out,
    output logic            mem_dq_oe,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data
);
    mem_op_e       cur_op;
    logic          rd_tail;
    logic [DW-1:0] keep_q;

    // Load the operation and address for the coming slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op   <= OP_IDLE;
            mem_addr <= '0;
        end else if (slot_end) begin
            cur_op <= new_op;
            if (new_op != OP_IDLE) mem_addr <= new_addr;
        end
    end

    // Extend the read strobe one clock past the end of a read slot.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_tail <= 1'b0;
        else        rd_tail <= slot_end && (cur_op == OP_READ);
    end

    // Capture read data at the end of a read slot and emit the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= slot_end && (cur_op == OP_READ);
            if (slot_end && (cur_op == OP_READ)) rd_data <= mem_dq_in;
        end
    end

    // Bus keeper: a new write byte, else a captured read byte, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else if (slot_end) begin
            if (new_op == OP_WRITE)      keep_q <= wr_byte;
            else if (cur_op == OP_READ)  keep_q <= mem_dq_in;
        end
    end

    // Decode the strobes from the slot operation and phase.
    always_comb begin
        mem_ce_n   = !((cur_op != OP_IDLE) && (phase != '0));
        mem_rd_n   = !((cur_op == OP_READ) || rd_tail);
        mem_wr_n   = !(cur_op == OP_WRITE);
        mem_dq_oe  = (cur_op == OP_WRITE);
        mem_dq_out = keep_q;
    end
endmodule

// File: rtl/dispmem_seq.sv
// Module dispmem_seq (top)
// Display memory access sequencer: it arbitrates refresh reads and buffered
// host writes into fixed three-clock RAM slots.
// Assumes: a single master clock; fetch_req is held until fetch_ack;
// fetch_ack is combinational from fetch_req within a slot's last clock.
module dispmem_seq
    import dispmem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    output logic          fetch_ack,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          host_wr_req,
    input  logic [AW-1:0] host_wr_addr,
    input  logic [DW-1:0] host_wr_data,
    output logic          host_wr_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    logic [PH_W-1:0] phase;
    logic            slot_end;
    logic            buf_full;
    logic            buf_pop;
    logic [AW-1:0]   buf_addr;
    logic [DW-1:0]   buf_data;
    mem_op_e         next_op;
    logic [AW-1:0]   next_addr;

    dms_slot_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .slot_end (slot_end)
    );

    dms_wr_buffer #(.AW(AW), .DW(DW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (host_wr_req),
        .push_addr (host_wr_addr),
        .push_data (host_wr_data),
        .pop       (buf_pop),
        .full      (buf_full),
        .addr      (buf_addr),
        .data      (buf_data)
    );

    dms_arbiter #(.AW(AW)) u_arb (
        .slot_end   (slot_end),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .buf_full   (buf_full),
        .buf_addr   (buf_addr),
        .next_op    (next_op),
        .next_addr  (next_addr),
        .fetch_ack  (fetch_ack),
        .buf_pop    (buf_pop)
    );

    dms_bus_ctrl #(.AW(AW), .DW(DW)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .slot_end   (slot_end),
        .new_op     (next_op),
        .new_addr   (next_addr),
        .wr_byte    (buf_data),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    // Buffer availability seen by the host.
    always_comb host_wr_ready = !buf_full;
endmodule

// File: rtl/dispmem_seq_chk.sv
// Module dispmem_seq_chk
// Protocol checker for the RAM side of dispmem_seq, bound to the top.
// Assumes: the synchronous active-low reset is held from time zero.
module dispmem_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_rd_n,
    input logic          mem_wr_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe,
    input logic          rd_valid
);
    // Enable low for exactly two clocks, then high again.
    assert_ce_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |=> !mem_ce_n ##1 mem_ce_n);

    // Address frozen while enable is low.
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> $stable(mem_addr));

    // Read strobe rises only after enable has been high for a clock.
    assert_rd_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |-> $past(mem_ce_n));

    // Read and write strobes never overlap inside an enable window.
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && !mem_wr_n) |-> mem_ce_n);

    // Write strobe and data set up before enable falls.
    assert_wr_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && !mem_wr_n) |-> ($past(!mem_wr_n) && $past(mem_dq_oe) && $stable(mem_dq_out)));

    // Kept byte changes only on a write or a read capture.
    assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_dq_out) |-> (mem_dq_oe || rd_valid));

    // Valid pulse follows a finished read window.
    assert_rd_valid_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_ce_n) && $past(!mem_rd_n) && mem_ce_n));
endmodule

bind dispmem_seq dispmem_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rd_valid   (rd_valid)
);

// File: tb/dispmem_seq_bench.sv
// Directed bench for dispmem_seq with a behavioural byte RAM model.
module dispmem_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_ack;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        host_wr_req = 1'b0;
    logic [15:0] host_wr_addr = '0;
    logic [7:0]  host_wr_data = '0;
    logic        host_wr_ready;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_rd_n, mem_wr_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] sram [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    dispmem_seq u_dispmem_seq (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .host_wr_req(host_wr_req), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_wr_ready(host_wr_ready),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // RAM model: drives stored byte while selected for read, noise otherwise.
    always @* begin
        if (!mem_ce_n && !mem_rd_n)
            mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'h5A;
    end

    // RAM model: store the byte while selected for write.
    always @(posedge clk)
        if (!mem_ce_n && !mem_wr_n && mem_dq_oe) sram[int'(mem_addr)] = mem_dq_out;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_ack();
        int guard = 0;
        #1;
        while (!fetch_ack && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        chk("R7", "fetch_ack seen", 32'(fetch_ack), 32'd1);
    endtask

    // R10: reset state at the ports.
    task automatic t_reset_state();
        @(negedge clk);
        chk("R10", "ce_n", 32'(mem_ce_n), 1);
        chk("R10", "rd_n", 32'(mem_rd_n), 1);
        chk("R10", "wr_n", 32'(mem_wr_n), 1);
        chk("R10", "oe", 32'(mem_dq_oe), 0);
        chk("R10", "rd_valid", 32'(rd_valid), 0);
        chk("R10", "ready", 32'(host_wr_ready), 1);
    endtask

    // R4, R5, R8: one host write and its slot shape.
    task automatic t_write(logic [15:0] a, logic [7:0] d);
        int guard = 0;
        @(negedge clk);
        while (!host_wr_ready) @(negedge clk);
        host_wr_req = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_req = 1'b0;
        chk("R8", "ready low while buffered", 32'(host_wr_ready), 0);
        while (mem_wr_n && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        chk("R4", "ph0 ce_n high", 32'(mem_ce_n), 1);
        chk("R4", "ph0 oe", 32'(mem_dq_oe), 1);
        chk("R4", "ph0 data", 32'(mem_dq_out), 32'(d));
        chk("R2", "write addr", 32'(mem_addr), 32'(a));
        @(negedge clk);
        chk("R1", "ph1 ce_n low", 32'(mem_ce_n), 0);
        chk("R4", "ph1 wr_n", 32'(mem_wr_n), 0);
        @(negedge clk);
        chk("R1", "ph2 ce_n low", 32'(mem_ce_n), 0);
        chk("R4", "ph2 data", 32'(mem_dq_out), 32'(d));
        @(negedge clk);
        chk("R1", "after slot ce_n high", 32'(mem_ce_n), 1);
        chk("R4", "wr_n released", 32'(mem_wr_n), 1);
        chk("R5", "oe released", 32'(mem_dq_oe), 0);
        chk("R5", "byte kept", 32'(mem_dq_out), 32'(d));
        chk("R8", "ready again", 32'(host_wr_ready), 1);
    endtask

    // R1, R3, R6, R7, R11: one refresh read with full slot checks.
    task automatic t_read(logic [15:0] a, logic [7:0] exp);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a;
        wait_ack();
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R1", "ph0 ce_n high", 32'(mem_ce_n), 1);
        chk("R3", "ph0 rd_n low", 32'(mem_rd_n), 0);
        chk("R2", "read addr", 32'(mem_addr), 32'(a));
        @(negedge clk);
        chk("R1", "ph1 ce_n low", 32'(mem_ce_n), 0);
        chk("R3", "ph1 rd_n low", 32'(mem_rd_n), 0);
        @(negedge clk);
        chk("R1", "ph2 ce_n low", 32'(mem_ce_n), 0);
        chk("R6", "no early valid", 32'(rd_valid), 0);
        @(negedge clk);
        chk("R1", "ce_n back high", 32'(mem_ce_n), 1);
        chk("R3", "rd_n tail", 32'(mem_rd_n), 0);
        chk("R6", "rd_valid", 32'(rd_valid), 1);
        chk("R11", "rd_data", 32'(rd_data), 32'(exp));
        chk("R5", "keeper shows read byte", 32'(mem_dq_out), 32'(exp));
        @(negedge clk);
        chk("R6", "valid one clock", 32'(rd_valid), 0);
        chk("R3", "rd_n released", 32'(mem_rd_n), 1);
    endtask

    // R8: fetch wins over a buffered write, write follows next slot.
    task automatic t_priority();
        @(negedge clk);
        while (!host_wr_ready) @(negedge clk);
        host_wr_req = 1'b1; host_wr_addr = 16'h0300; host_wr_data = 8'hC3;
        @(negedge clk);
        host_wr_req = 1'b0;
        fetch_req = 1'b1; fetch_addr = 16'h0100;
        chk("R8", "buffer full", 32'(host_wr_ready), 0);
        wait_ack();
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R8", "read slot first rd_n", 32'(mem_rd_n), 0);
        chk("R8", "read slot first wr_n", 32'(mem_wr_n), 1);
        chk("R8", "write still waiting", 32'(host_wr_ready), 0);
        repeat (3) @(negedge clk);
        chk("R8", "write slot next wr_n", 32'(mem_wr_n), 0);
        chk("R8", "write slot addr", 32'(mem_addr), 32'h0300);
        chk("R6", "read byte during write slot", 32'(rd_data), 32'h5E);
        repeat (3) @(negedge clk);
    endtask

    // R9: idle slots keep strobes high; a held fetch is taken every 3 clocks.
    task automatic t_idle_and_rate();
        int low = 0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (!mem_ce_n || !mem_rd_n || !mem_wr_n) low++;
        end
        chk("R9", "idle strobes high", 32'(low), 0);
        fetch_req = 1'b1; fetch_addr = 16'h0100;
        wait_ack();
        @(negedge clk);
        fetch_addr = 16'h0300;
        chk("R9", "no ack at +1", 32'(fetch_ack), 0);
        @(negedge clk);
        chk("R9", "no ack at +2", 32'(fetch_ack), 0);
        @(negedge clk);
        chk("R9", "ack at +3", 32'(fetch_ack), 1);
        @(negedge clk);
        fetch_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "second read byte", 32'(rd_data), 32'hC3);
    endtask

    // R10: reset while a write is stuck behind fetches drops the write.
    task automatic t_reset_drop();
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 16'h0200;
        host_wr_req = 1'b1; host_wr_addr = 16'h1234; host_wr_data = 8'h99;
        @(negedge clk);
        host_wr_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        fetch_req = 1'b0;
        @(negedge clk);
        chk("R10", "ready after reset", 32'(host_wr_ready), 1);
        chk("R10", "ce_n after reset", 32'(mem_ce_n), 1);
        chk("R10", "rd_n after reset", 32'(mem_rd_n), 1);
        chk("R10", "wr_n after reset", 32'(mem_wr_n), 1);
        chk("R10", "oe after reset", 32'(mem_dq_oe), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10", "dropped write never issued", 32'(sram[32'h1234]), 32'h11);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_write(16'h0100, 8'h5E);
        t_read(16'h0100, 8'h5E);
        t_write(16'h1234, 8'h11);
        t_priority();
        t_read(16'h0300, 8'hC3);
        t_idle_and_rate();
        t_write(16'hFFFF, 8'hA7);
        t_write(16'hF000, 8'h3C);
        t_write(16'h0000, 8'h81);
        t_read(16'hFFFF, 8'hA7);
        t_read(16'hF000, 8'h3C);
        t_read(16'h0000, 8'h81);
        t_read(16'h4444, 8'h00);
        t_reset_drop();
        t_read(16'h1234, 8'h11);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule